// File: doc/BRIEF.md
# DRAM Presence-Detect Parameter Decoder

This block turns the contents of a memory module's presence-detect storage into settings a DRAM controller can use. After a start pulse it fetches six bytes, one at a time, through a simple request/response byte port. From those bytes it works out four results. The first is one timing parameter in half-picosecond units, built from a 125 ps coarse count plus a signed fine correction. The second is that timing rounded up to whole clock cycles of a given period. The third is the module capacity in megabits. The fourth is the fastest supported CAS latency.

The byte port holds `rd_req_o` high with a stable `rd_addr_o` until the source answers with `rd_valid_i` and `rd_data_i`. Only one read is outstanding at a time. The cycle count comes from an iterative subtract divider, so the time to finish grows with the cycle count. `tck_ps_i` and `fine_sel_i` must stay constant from the start pulse until `done_o` rises. Results are registered together on completion and remain unchanged until the next run completes.

Top module: `spd_decoder`

## Requirements
- R1: While reset is asserted and directly after it, `rd_req_o` and `done_o` are low, and the time, cycle and capacity outputs are zero.
- R2: A start pulse while idle or done begins a run that reads addresses 4, 7, 8, 18, 12, 34 in that order. For each read, `rd_req_o` stays high and `rd_addr_o` stays stable until `rd_valid_i` is seen. Exactly six reads are made per run.
- R3: `time_hps_o` = 250 × byte12 + signed(byte34) × k. Here k is 2 when `fine_sel_i` = 0 (1 ps steps), 5 when it is 1 (2.5 ps steps), and 10 when it is 2 or 3 (5 ps steps).
- R4: `cycles_o` = ceil(`time_hps_o` / (2 × `tck_ps_i`)) and `time_err_o` = 0. If the time is zero or negative, or `tck_ps_i` is zero, then `cycles_o` = 0 and `time_err_o` = 1.
- R5: Capacity uses d = byte4[3:0], w = byte7[2:0], ranks = byte7[5:3]+1 and b = byte8[2:0]. It is `cap_mbit_o` = ranks × (256 << (d + b + 1 − w)), which equals chips per rank (8<<b)/(4<<w) × per-chip density (256<<d Mbit) × ranks. Byte bits outside these fields are ignored.
- R6: `cfg_err_o` is 1 and `cap_mbit_o` is 0 when d > 6, w > 3, b > 3, or b + 1 < w.
- R7: `cas_o` is one plus the index of the highest set bit among byte18[6:0], and `cas_err_o` is 0. Bit 7 is ignored. With no bit set in [6:0], `cas_o` = 0 and `cas_err_o` = 1.
- R8: `done_o` rises when the results are updated. It stays high, with every result output unchanged, until the next start pulse. Start pulses during a run are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a decode run |
| tck_ps_i | input | 16 | Controller clock period in ps |
| fine_sel_i | input | 2 | Fine correction step select |
| rd_req_o | output | 1 | Byte read request |
| rd_addr_o | output | 8 | Byte address being read |
| rd_valid_i | input | 1 | Read data valid strobe |
| rd_data_i | input | 8 | Read data byte |
| done_o | output | 1 | Results valid |
| time_hps_o | output | 18 | Signed timing in half-picoseconds |
| cycles_o | output | 16 | Timing rounded up to clock cycles |
| time_err_o | output | 1 | Timing not positive or zero period |
| cap_mbit_o | output | 24 | Module capacity in megabits |
| cfg_err_o | output | 1 | Invalid organisation fields |
| cas_o | output | 3 | Selected CAS latency |
| cas_err_o | output | 1 | No supported CAS latency |

## Verification
Random runs draw the field codes and fine corrections across their full ranges, so valid and invalid organisations, positive and negative corrections, and all three fine steps appear together with varying read latencies. Directed runs put the time exactly on a cycle multiple and one fine step either side of it, which separates ceiling rounding from truncation and catches a dropped sign on the correction. Further directed runs cover zero and negative times and a zero period (the error path), an empty latency mask and a mask with only bit 7 set (bit 7 ignored), and a device wider than the bus (rejected). The requested address order is compared on every read, which catches any reordering or repeated read.

// File: rtl/spd_pkg.sv
package spd_pkg;
  typedef enum logic [1:0] {S_IDLE, S_READ, S_CALC, S_DONE} spd_state_e;

  localparam int unsigned NUM_RD  = 6;
  localparam int unsigned IDX_DEN = 0;
  localparam int unsigned IDX_ORG = 1;
  localparam int unsigned IDX_WID = 2;
  localparam int unsigned IDX_CAS = 3;
  localparam int unsigned IDX_MTB = 4;
  localparam int unsigned IDX_FTB = 5;

  function automatic logic [7:0] rd_addr(input logic [2:0] idx);
    case (idx)
      3'd0:    rd_addr = 8'd4;
      3'd1:    rd_addr = 8'd7;
      3'd2:    rd_addr = 8'd8;
      3'd3:    rd_addr = 8'd18;
      3'd4:    rd_addr = 8'd12;
      default: rd_addr = 8'd34;
    endcase
  endfunction
endpackage

// File: rtl/spd_read_fsm.sv
module spd_read_fsm
  import spd_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic                    rd_valid_i,
  input  logic [7:0]              rd_data_i,
  input  logic                    div_done_i,
  output logic                    rd_req_o,
  output logic [7:0]              rd_addr_o,
  output logic                    go_o,
  output logic                    done_o,
  output logic [NUM_RD-1:0][7:0]  bytes_o
);
  localparam logic [2:0] LAST = 3'(NUM_RD - 1);

  spd_state_e state_q;
  logic [2:0] idx_q;
  logic       go_q;
  logic [NUM_RD-1:0][7:0] bytes_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
      go_q    <= 1'b0;
      bytes_q <= '0;
    end else begin
      go_q <= 1'b0;
      case (state_q)
        S_IDLE, S_DONE: if (start_i) begin
          state_q <= S_READ;
          idx_q   <= '0;
        end
        S_READ: if (rd_valid_i) begin
          bytes_q[idx_q] <= rd_data_i;
          if (idx_q == LAST) begin
            state_q <= S_CALC;
            go_q    <= 1'b1;
          end else begin
            idx_q <= idx_q + 3'd1;
          end
        end
        S_CALC: if (div_done_i) state_q <= S_DONE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign rd_req_o  = (state_q == S_READ);
  assign rd_addr_o = rd_addr(idx_q);
  assign go_o      = go_q;
  assign done_o    = (state_q == S_DONE);
  assign bytes_o   = bytes_q;

  // R2: request and address held until the strobe
  a_r2_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_valid_i |=> rd_req_o && $stable(rd_addr_o));
  // R8: a start pulse mid-run does not restart the sequence
  a_r8_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_valid_i && start_i |=> $stable(rd_addr_o));
endmodule

// File: rtl/spd_time_calc.sv
module spd_time_calc #(
  parameter int unsigned TIME_W  = 18,
  parameter int unsigned MTB_HPS = 250
) (
  input  logic [7:0]               mtb_i,
  input  logic [7:0]               fine_i,
  input  logic [1:0]               fine_sel_i,
  output logic signed [TIME_W-1:0] time_o
);
  logic [TIME_W-1:0]        coarse;
  logic signed [TIME_W-1:0] fine_ext, scale;

  assign coarse   = TIME_W'(mtb_i) * TIME_W'(MTB_HPS);
  assign fine_ext = TIME_W'($signed(fine_i));

  always_comb begin
    case (fine_sel_i)
      2'd0:    scale = TIME_W'(2);
      2'd1:    scale = TIME_W'(5);
      default: scale = TIME_W'(10);
    endcase
  end

  assign time_o = $signed(coarse) + fine_ext * scale;
endmodule

// File: rtl/spd_cfg_calc.sv
module spd_cfg_calc #(
  parameter int unsigned CAP_W     = 24,
  parameter int unsigned BASE_MBIT = 256,
  parameter int unsigned MAX_DENS  = 6,
  parameter int unsigned MAX_CODE  = 3,
  parameter int unsigned CAS_BITS  = 7,
  localparam int unsigned CAS_W    = $clog2(CAS_BITS + 1)
) (
  input  logic [7:0]       dens_i,
  input  logic [7:0]       org_i,
  input  logic [7:0]       wid_i,
  input  logic [7:0]       cas_mask_i,
  output logic [CAP_W-1:0] cap_o,
  output logic             cfg_err_o,
  output logic [CAS_W-1:0] cas_o,
  output logic             cas_err_o
);
  logic [3:0] d, ranks;
  logic [2:0] w, b;
  logic [4:0] shift;

  assign d     = dens_i[3:0];
  assign w     = org_i[2:0];
  assign ranks = {1'b0, org_i[5:3]} + 4'd1;
  assign b     = wid_i[2:0];
  assign shift = 5'(d) + 5'(b) + 5'd1 - 5'(w);

  assign cfg_err_o = (32'(d) > MAX_DENS) || (32'(w) > MAX_CODE) ||
                     (32'(b) > MAX_CODE) || ({1'b0, b} + 4'd1 < {1'b0, w});
  assign cap_o = cfg_err_o ? '0 : CAP_W'(ranks) * (CAP_W'(BASE_MBIT) << shift);

  // highest set bit is the fastest supported latency
  always_comb begin
    cas_o = '0;
    for (int i = 0; i < CAS_BITS; i++)
      if (cas_mask_i[i]) cas_o = CAS_W'(i + 1);
  end
  assign cas_err_o = (cas_o == '0);
endmodule

// File: rtl/spd_cyc_div.sv
module spd_cyc_div #(
  parameter int unsigned TIME_W = 18,
  parameter int unsigned TCK_W  = 16,
  parameter int unsigned CNT_W  = 16,
  localparam int unsigned DIV_W = TCK_W + 1,
  localparam int unsigned REM_W = TIME_W + 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic signed [TIME_W-1:0] dividend_i,
  input  logic [DIV_W-1:0]         divisor_i,
  output logic                     done_o,
  output logic                     err_o,
  output logic [CNT_W-1:0]         quot_o
);
  logic signed [REM_W-1:0] rem_q, rem_n;
  logic [CNT_W-1:0] quot_q;
  logic run_q, done_q, err_q;

  assign rem_n = rem_q - $signed(REM_W'(divisor_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0; quot_q <= '0; run_q <= 1'b0; done_q <= 1'b0; err_q <= 1'b0;
    end else if (start_i) begin
      quot_q <= '0;
      rem_q  <= REM_W'(dividend_i);
      if (dividend_i <= 0 || divisor_i == '0) begin
        run_q <= 1'b0; done_q <= 1'b1; err_q <= 1'b1;
      end else begin
        run_q <= 1'b1; done_q <= 1'b0; err_q <= 1'b0;
      end
    end else if (run_q) begin
      rem_q  <= rem_n;
      quot_q <= quot_q + 1'b1;
      if (rem_n <= 0) begin
        run_q  <= 1'b0;
        done_q <= 1'b1;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  assign done_o = done_q;
  assign err_o  = err_q;
  assign quot_o = quot_q;

  // R4: a successful division counts at least one cycle, never wraps
  a_r4_quot_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !err_o |-> quot_o != '0);
  a_r4_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> quot_q != '1);
  a_r4_err_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && err_o |-> quot_o == '0);
endmodule

// File: rtl/spd_decoder.sv
module spd_decoder
  import spd_pkg::*;
#(
  parameter int unsigned TCK_W  = 16,
  parameter int unsigned TIME_W = 18,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned CAP_W  = 24
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [TCK_W-1:0]         tck_ps_i,
  input  logic [1:0]               fine_sel_i,
  output logic                     rd_req_o,
  output logic [7:0]               rd_addr_o,
  input  logic                     rd_valid_i,
  input  logic [7:0]               rd_data_i,
  output logic                     done_o,
  output logic signed [TIME_W-1:0] time_hps_o,
  output logic [CNT_W-1:0]         cycles_o,
  output logic                     time_err_o,
  output logic [CAP_W-1:0]         cap_mbit_o,
  output logic                     cfg_err_o,
  output logic [2:0]               cas_o,
  output logic                     cas_err_o
);
  logic [NUM_RD-1:0][7:0] bytes;
  logic go, div_done, div_err, cfg_err, cas_err;
  logic signed [TIME_W-1:0] time_hps;
  logic [CNT_W-1:0] quot;
  logic [CAP_W-1:0] cap;
  logic [2:0] cas;

  spd_read_fsm u_fsm (
    .clk_i, .rst_ni, .start_i, .rd_valid_i, .rd_data_i,
    .div_done_i(div_done), .rd_req_o, .rd_addr_o,
    .go_o(go), .done_o, .bytes_o(bytes)
  );

  spd_time_calc #(.TIME_W(TIME_W)) u_time (
    .mtb_i(bytes[IDX_MTB]), .fine_i(bytes[IDX_FTB]),
    .fine_sel_i, .time_o(time_hps)
  );

  spd_cfg_calc #(.CAP_W(CAP_W)) u_cfg (
    .dens_i(bytes[IDX_DEN]), .org_i(bytes[IDX_ORG]), .wid_i(bytes[IDX_WID]),
    .cas_mask_i(bytes[IDX_CAS]), .cap_o(cap), .cfg_err_o(cfg_err),
    .cas_o(cas), .cas_err_o(cas_err)
  );

  spd_cyc_div #(.TIME_W(TIME_W), .TCK_W(TCK_W), .CNT_W(CNT_W)) u_div (
    .clk_i, .rst_ni, .start_i(go), .dividend_i(time_hps),
    .divisor_i({tck_ps_i, 1'b0}), .done_o(div_done), .err_o(div_err), .quot_o(quot)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      time_hps_o <= '0; cycles_o <= '0; time_err_o <= 1'b0;
      cap_mbit_o <= '0; cfg_err_o <= 1'b0; cas_o <= '0; cas_err_o <= 1'b0;
    end else if (div_done) begin
      time_hps_o <= time_hps; cycles_o <= quot; time_err_o <= div_err;
      cap_mbit_o <= cap; cfg_err_o <= cfg_err; cas_o <= cas; cas_err_o <= cas_err;
    end
  end

  // R8: results frozen while done and no new start
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o && $stable(cycles_o) && $stable(cap_mbit_o)
                          && $stable(time_hps_o) && $stable(cas_o));
  // R6: an invalid organisation never reports capacity
  a_r6_cap_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> cap_mbit_o == '0);
  // R2: no byte request while results are presented
  a_r2_quiet_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !rd_req_o);
endmodule

// File: tb/spd_decoder_test.sv
`timescale 1ns/1ps
module spd_decoder_test;
  logic clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic [15:0] tck_ps_i = '0;
  logic [1:0]  fine_sel_i = '0;
  logic rd_req_o, rd_valid_i = 1'b0;
  logic [7:0] rd_addr_o, rd_data_i = '0;
  logic done_o, time_err_o, cfg_err_o, cas_err_o;
  logic signed [17:0] time_hps_o;
  logic [15:0] cycles_o;
  logic [23:0] cap_mbit_o;
  logic [2:0]  cas_o;

  int n_chk = 0, n_fail = 0;
  logic [7:0] mem [256];
  int seq [6] = '{4, 7, 8, 18, 12, 34};

  always #10 clk_i = ~clk_i;

  spd_decoder uut (.*);

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic int e_time(input int mtb, input int ftb, input int sel);
    int f = (ftb > 127) ? ftb - 256 : ftb;
    int k = (sel == 0) ? 2 : (sel == 1) ? 5 : 10;
    return mtb * 250 + f * k;
  endfunction

  function automatic int e_cyc(input int t, input int tck);
    if (t <= 0 || tck == 0) return 0;
    return (t + 2 * tck - 1) / (2 * tck);
  endfunction

  function automatic bit e_cfg_bad(input int den, input int org, input int wid);
    int d = den & 15, w = org & 7, b = wid & 7;
    return (d > 6) || (w > 3) || (b > 3) || (b + 1 < w);
  endfunction

  function automatic int e_cap(input int den, input int org, input int wid);
    int d = den & 15, w = org & 7, b = wid & 7, r = ((org >> 3) & 7) + 1;
    if (e_cfg_bad(den, org, wid)) return 0;
    return r * (256 << (d + b + 1 - w));
  endfunction

  function automatic int e_cas(input int m);
    int c = 0;
    for (int i = 0; i < 7; i++) if (m[i]) c = i + 1;
    return c;
  endfunction

  task automatic run_case(input int den, org, wid, cas, mtb, ftb, sel, tck);
    int k = 0, cyc = 0, t;
    logic [15:0] c_snap;
    logic [23:0] cap_snap;
    mem[4] = 8'(den); mem[7] = 8'(org); mem[8] = 8'(wid);
    mem[18] = 8'(cas); mem[12] = 8'(mtb); mem[34] = 8'(ftb);
    tck_ps_i = 16'(tck); fine_sel_i = 2'(sel);
    @(negedge clk_i) start_i = 1'b1;
    @(negedge clk_i) start_i = 1'b0;
    while (!done_o && cyc < 60000) begin
      @(negedge clk_i); cyc++;
      rd_valid_i = 1'b0;
      if (rd_req_o) begin
        if (k < 6) chk(rd_addr_o == 8'(seq[k]), "R2 address order", rd_addr_o, seq[k]);
        else chk(0, "R2 extra read", k, 6);
        if (k == 2) start_i = 1'b1;  // R8: ignored mid-run
        repeat ($urandom % 3) @(negedge clk_i);
        start_i = 1'b0;
        rd_valid_i = 1'b1; rd_data_i = mem[rd_addr_o]; k++;
      end
    end
    rd_valid_i = 1'b0;
    chk(k == 6, "R2 read count", k, 6);
    t = e_time(mtb, ftb, sel);
    chk(done_o == 1'b1, "R8 done", done_o, 1);
    chk(time_hps_o == 18'(t), "R3 time", time_hps_o, t);
    chk(cycles_o == 16'(e_cyc(t, tck)), "R4 cycles", cycles_o, e_cyc(t, tck));
    chk(time_err_o == (t <= 0 || tck == 0), "R4 time error", time_err_o, (t <= 0 || tck == 0));
    chk(cap_mbit_o == 24'(e_cap(den, org, wid)), "R5 capacity", cap_mbit_o, e_cap(den, org, wid));
    chk(cfg_err_o == e_cfg_bad(den, org, wid), "R6 config error", cfg_err_o, e_cfg_bad(den, org, wid));
    chk(cas_o == 3'(e_cas(cas)), "R7 CAS", cas_o, e_cas(cas));
    chk(cas_err_o == (e_cas(cas) == 0), "R7 CAS error", cas_err_o, e_cas(cas) == 0);
    c_snap = cycles_o; cap_snap = cap_mbit_o;
    repeat (4) @(negedge clk_i);
    chk(done_o && cycles_o == c_snap && cap_mbit_o == cap_snap, "R8 hold", cycles_o, c_snap);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk_i);
    // R1: reset state
    chk(!rd_req_o && !done_o, "R1 reset controls", {rd_req_o, done_o}, 0);
    chk(cycles_o == 0 && cap_mbit_o == 0 && time_hps_o == 0, "R1 reset results", cap_mbit_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!rd_req_o && !done_o, "R1 after reset", {rd_req_o, done_o}, 0);

    // R4: exact multiple and one fine step either side
    run_case(2, 8'h09, 3, 8'h38, 8, 0, 0, 1000);
    run_case(2, 8'h09, 3, 8'h38, 8, 8'hFF, 0, 1000);
    run_case(2, 8'h09, 3, 8'h38, 8, 1, 0, 1000);
    // R3: negative correction with 2.5 ps and 5 ps steps
    run_case(4, 8'h01, 3, 8'h0E, 11, 8'hCA, 1, 1250);
    run_case(4, 8'h01, 3, 8'h0E, 11, 8'h81, 3, 1250);
    // R4: zero time, negative time, zero period
    run_case(0, 8'h00, 0, 8'h01, 0, 0, 0, 1000);
    run_case(0, 8'h00, 0, 8'h01, 0, 8'h80, 2, 1000);
    run_case(0, 8'h00, 0, 8'h01, 20, 0, 0, 0);
    // R7: empty mask, bit 7 only
    run_case(6, 8'h3B, 3, 8'h00, 15, 8'hF0, 0, 937);
    run_case(6, 8'h3B, 3, 8'h80, 15, 8'hF0, 0, 937);
    // R6: device wider than bus, density out of range; R5 largest
    run_case(1, 8'h03, 1, 8'h7F, 10, 0, 2, 1500);
    run_case(7, 8'h00, 3, 8'h7F, 10, 0, 2, 1500);
    run_case(6, 8'h38, 3, 8'h7F, 255, 127, 2, 7);

    for (int i = 0; i < 40; i++)
      run_case($urandom % 8 + ($urandom % 2) * 16, $urandom % 256, $urandom % 6 + ($urandom % 2) * 64,
               $urandom % 256, $urandom % 256, $urandom % 256, $urandom % 4,
               800 + $urandom % 2000);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule